// File: doc/BRIEF.md
# DMA Beat Address Generator

This block computes the source and destination byte addresses for each beat of one DMA block transfer. A start pulse captures both start addresses, the number of beats, the beat width code, separate increment enables for the two sides, a step-select bit and a 3-bit step field. The registered outputs show the addresses for the current beat and the beats still to run. Each accepted beat-done pulse moves every incrementing side forward by its stride and reduces the count by one. When the count reaches zero, the block raises a done flag.

Only one side can use the multi-beat stride. When step-select is 1, the source takes a stride of 2^field beats. When it is 0, the destination takes that stride. An incrementing side that is not selected always moves by one beat. A fixed side holds its start address for the whole block. Bus mastering and data movement, channel arbitration, descriptor fetching, triggers and interrupts belong to other blocks.

Top module: `dma_beat_addr_gen`

## Requirements
- R1: While reset is high and after it is released, both addresses and the remaining count read 0, busy is 0 and done is 0.
- R2: On the edge where start is high, both addresses load their start values, the remaining count loads the beat count, and busy goes to 1 if the count is not zero. These values appear in the cycle after the start pulse.
- R3: A side whose increment enable was 0 at start keeps its start address unchanged for every beat of the block.
- R4: With step-select 1, an incrementing source advances by (2^field) × beat bytes per beat, and an incrementing destination advances by one beat.
- R5: With step-select 0, an incrementing destination advances by (2^field) × beat bytes per beat, and an incrementing source advances by one beat.
- R6: Beat width code 0 means 1 byte, code 1 means 2 bytes, code 2 means 4 bytes, and the reserved code 3 is treated as 4 bytes. Field values 0 to 7 give strides of 1 to 128 beats.
- R7: Each accepted beat-done pulse decrements the remaining count, and the new addresses and count appear in the next cycle. On the pulse that reaches zero, busy falls and done rises in the same cycle, and busy and done are never both 1.
- R8: A start with a beat count of 0 gives busy 0 and done 1 in the next cycle.
- R9: A beat-done pulse while busy is 0 does not change the addresses, the remaining count or done.
- R10: Addresses wrap modulo 2^32 with no error indication.
- R11: The configuration is captured at start. Changing the increment enables, step controls or beat width during a block does not change its strides.
- R12: A start pulse during a running block discards that block and loads the new configuration. When start and beat-done are high together, start takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load the configuration and begin a block |
| beat_done_i | input | 1 | One beat has finished |
| src_start_i | input | 32 | Source start byte address |
| dst_start_i | input | 32 | Destination start byte address |
| beat_cnt_i | input | 16 | Number of beats in the block |
| beat_code_i | input | 2 | Beat width code (0: 1 B, 1: 2 B, 2/3: 4 B) |
| src_inc_i | input | 1 | Source address increments |
| dst_inc_i | input | 1 | Destination address increments |
| step_sel_i | input | 1 | 1: step applies to source, 0: to destination |
| step_field_i | input | 3 | Stride exponent, 2^field beats |
| src_addr_o | output | 32 | Source address for the current beat |
| dst_addr_o | output | 32 | Destination address for the current beat |
| remaining_o | output | 16 | Beats still to run |
| busy_o | output | 1 | Block in progress |
| done_o | output | 1 | Block completed |

## Verification
A wrong latched stride, or a wrong step-select routing, shows on an address output one cycle after the first beat-done pulse, because the first beat always presents the start address. A count register that is off by one moves the rise of done one beat earlier or later. A control bit that escapes its latch shows as a different stride on the beat after the inputs change in the middle of a block. If the busy qualifier is lost, a late beat-done pulse moves the addresses and the count away from their final values on the next cycle.

// File: rtl/dma_bag_pkg.sv
package dma_bag_pkg;

  localparam int NUM_SIDES = 2;
  localparam int SIDE_SRC  = 0;
  localparam int SIDE_DST  = 1;

  typedef enum logic [1:0] {
    BEAT_1B  = 2'd0,
    BEAT_2B  = 2'd1,
    BEAT_4B  = 2'd2,
    BEAT_RSV = 2'd3
  } beat_code_e;

  // log2 of the beat width in bytes; reserved code behaves as 4 bytes
  function automatic logic [1:0] beat_shift(input beat_code_e code);
    case (code)
      BEAT_1B: return 2'd0;
      BEAT_2B: return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/bag_stride_calc.sv
module bag_stride_calc
  import dma_bag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STEP_W = 3
) (
  input  logic [1:0]        beat_code_i,
  input  logic [STEP_W-1:0] step_field_i,
  input  logic              use_step_i,
  output logic [ADDR_W-1:0] stride_o
);
  localparam int MAX_SHIFT = (2 ** STEP_W) - 1 + 2;
  localparam int SH_W      = $clog2(MAX_SHIFT + 1);

  logic [SH_W-1:0] shift;

  always_comb begin
    shift = SH_W'(beat_shift(beat_code_e'(beat_code_i)));
    if (use_step_i) begin
      shift = shift + SH_W'(step_field_i);
    end
    stride_o = ADDR_W'(1) << shift;
  end
endmodule

// File: rtl/bag_addr_side.sv
module bag_addr_side #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              inc_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic              advance_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] stride_q;
  logic              inc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      stride_q <= ADDR_W'(1);
      inc_q    <= 1'b0;
    end else if (load_i) begin
      addr_q   <= start_addr_i;
      stride_q <= stride_i;
      inc_q    <= inc_i;
    end else if (advance_i && inc_q) begin
      addr_q   <= addr_q + stride_q;
    end
  end

  assign addr_o = addr_q;

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> addr_q == $past(start_addr_i));

  assert_fixed_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !inc_q) |=> $stable(addr_q));

  assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
    (!load_i && advance_i && inc_q) |=> addr_q == $past(addr_q) + $past(stride_q));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !advance_i) |=> $stable(addr_q));

  assert_stride_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    inc_q |-> $onehot(stride_q));
endmodule

// File: rtl/bag_beat_counter.sv
module bag_beat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             beat_i,
  output logic             advance_o,
  output logic [CNT_W-1:0] remaining_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] rem_q;
  logic             busy_q;
  logic             done_q;

  assign advance_o = beat_i && busy_q && !load_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (load_i) begin
      rem_q  <= count_i;
      busy_q <= (count_i != '0);
      done_q <= (count_i == '0);
    end else if (advance_o) begin
      rem_q <= rem_q - CNT_W'(1);
      if (rem_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign remaining_o = rem_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;

  assert_dec_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && beat_i && !load_i) |=> rem_q == $past(rem_q) - CNT_W'(1));

  assert_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(busy_q && done_q));

  assert_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (load_i && count_i == '0) |=> (done_q && !busy_q));

  assert_ignore_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !load_i) |=> ($stable(rem_q) && $stable(done_q)));
endmodule

// File: rtl/dma_beat_addr_gen.sv
module dma_beat_addr_gen
  import dma_bag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              beat_done_i,
  input  logic [ADDR_W-1:0] src_start_i,
  input  logic [ADDR_W-1:0] dst_start_i,
  input  logic [CNT_W-1:0]  beat_cnt_i,
  input  logic [1:0]        beat_code_i,
  input  logic              src_inc_i,
  input  logic              dst_inc_i,
  input  logic              step_sel_i,
  input  logic [STEP_W-1:0] step_field_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic [CNT_W-1:0]  remaining_o,
  output logic              busy_o,
  output logic              done_o
);
  logic                  advance;
  logic [ADDR_W-1:0]     side_start [NUM_SIDES];
  logic                  side_inc   [NUM_SIDES];
  logic                  side_use   [NUM_SIDES];
  logic [ADDR_W-1:0]     side_stride[NUM_SIDES];
  logic [ADDR_W-1:0]     side_addr  [NUM_SIDES];

  assign side_start[SIDE_SRC] = src_start_i;
  assign side_start[SIDE_DST] = dst_start_i;
  assign side_inc[SIDE_SRC]   = src_inc_i;
  assign side_inc[SIDE_DST]   = dst_inc_i;
  // step-select steers the multi-beat stride to exactly one side
  assign side_use[SIDE_SRC]   = step_sel_i;
  assign side_use[SIDE_DST]   = !step_sel_i;

  bag_beat_counter #(.CNT_W(CNT_W)) counter_i (
    .clk         (clk),
    .rst         (rst),
    .load_i      (start_i),
    .count_i     (beat_cnt_i),
    .beat_i      (beat_done_i),
    .advance_o   (advance),
    .remaining_o (remaining_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
    bag_stride_calc #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) stride_i (
      .beat_code_i  (beat_code_i),
      .step_field_i (step_field_i),
      .use_step_i   (side_use[g]),
      .stride_o     (side_stride[g])
    );

    bag_addr_side #(.ADDR_W(ADDR_W)) addr_i (
      .clk          (clk),
      .rst          (rst),
      .load_i       (start_i),
      .start_addr_i (side_start[g]),
      .inc_i        (side_inc[g]),
      .stride_i     (side_stride[g]),
      .advance_i    (advance),
      .addr_o       (side_addr[g])
    );
  end

  assign src_addr_o = side_addr[SIDE_SRC];
  assign dst_addr_o = side_addr[SIDE_DST];

  assert_restart_R12: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (remaining_o == $past(beat_cnt_i) && src_addr_o == $past(src_start_i)
                 && dst_addr_o == $past(dst_start_i)));

  assert_late_beat_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i && beat_done_i) |=>
      ($stable(src_addr_o) && $stable(dst_addr_o) && $stable(remaining_o)));
endmodule

// File: tb/dma_beat_addr_gen_tb_top.sv
module dma_beat_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        beat = 1'b0;
  logic [31:0] src_s = '0, dst_s = '0;
  logic [15:0] cnt = '0;
  logic [1:0]  code = '0;
  logic        si = 1'b0, di = 1'b0, sel = 1'b0;
  logic [2:0]  fld = '0;
  logic [31:0] src_a, dst_a;
  logic [15:0] rem;
  logic        busy, done;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  dma_beat_addr_gen dut_i (
    .clk(clk), .rst(rst), .start_i(start), .beat_done_i(beat),
    .src_start_i(src_s), .dst_start_i(dst_s), .beat_cnt_i(cnt),
    .beat_code_i(code), .src_inc_i(si), .dst_inc_i(di),
    .step_sel_i(sel), .step_field_i(fld),
    .src_addr_o(src_a), .dst_addr_o(dst_a), .remaining_o(rem),
    .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_stride(input logic [1:0] c, input logic [2:0] f,
                                             input logic chosen);
    logic [31:0] b;
    b = (c == 2'd3) ? 32'd4 : (32'd1 << c);
    return chosen ? (b << f) : b;
  endfunction

  task automatic start_blk(input logic [31:0] s, input logic [31:0] d, input logic [15:0] n,
                           input logic [1:0] c, input logic sinc, input logic dinc,
                           input logic ssel, input logic [2:0] f);
    src_s = s; dst_s = d; cnt = n; code = c; si = sinc; di = dinc; sel = ssel; fld = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic beat_pulse();
    beat = 1'b1;
    @(negedge clk);
    beat = 1'b0;
  endtask

  // full block with per-beat checks
  task automatic run_block(input string req, input logic [31:0] s, input logic [31:0] d,
                           input logic [15:0] n, input logic [1:0] c, input logic sinc,
                           input logic dinc, input logic ssel, input logic [2:0] f);
    logic [31:0] ss, ds;
    ss = sinc ? exp_stride(c, f, ssel)  : 32'd0;
    ds = dinc ? exp_stride(c, f, !ssel) : 32'd0;
    start_blk(s, d, n, c, sinc, dinc, ssel, f);
    chk({req, " R2 src load"}, src_a, s);
    chk({req, " R2 dst load"}, dst_a, d);
    chk({req, " R2 count load"}, {16'd0, rem}, {16'd0, n});
    chk({req, " R2 busy"}, {31'd0, busy}, 32'd1);
    for (int k = 1; k <= int'(n); k++) begin
      beat_pulse();
      chk({req, " src"}, src_a, s + ss * k);
      chk({req, " dst"}, dst_a, d + ds * k);
      chk({req, " R7 remaining"}, {16'd0, rem}, 32'(int'(n) - k));
    end
    chk({req, " R7 done"}, {31'd0, done}, 32'd1);
    chk({req, " R7 busy low"}, {31'd0, busy}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 src", src_a, 32'd0);
    chk("R1 dst", dst_a, 32'd0);
    chk("R1 rem", {16'd0, rem}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
  endtask

  task automatic t_src_step();   // R4
    run_block("R4 sel1", 32'h0000_1000, 32'h0000_2000, 16'd4, 2'd2, 1'b1, 1'b1, 1'b1, 3'd1);
  endtask

  task automatic t_dst_step();   // R5
    run_block("R5 sel0", 32'h0000_3000, 32'h0000_4000, 16'd3, 2'd1, 1'b1, 1'b1, 1'b0, 3'd3);
  endtask

  task automatic t_fixed();      // R3
    run_block("R3 src fixed", 32'h0000_5555, 32'h0000_0100, 16'd3, 2'd0, 1'b0, 1'b1, 1'b1, 3'd2);
    run_block("R3 dst fixed", 32'h0000_0200, 32'h0000_7777, 16'd2, 2'd2, 1'b1, 1'b0, 1'b0, 3'd5);
  endtask

  task automatic t_widths();     // R6
    run_block("R6 code3", 32'h0000_0040, 32'h0, 16'd2, 2'd3, 1'b1, 1'b0, 1'b1, 3'd0);
    run_block("R6 code0", 32'h0000_0040, 32'h0, 16'd2, 2'd0, 1'b1, 1'b0, 1'b1, 3'd0);
    run_block("R6 field7", 32'h0001_0000, 32'h0, 16'd2, 2'd2, 1'b1, 1'b0, 1'b1, 3'd7);
  endtask

  task automatic t_zero();       // R8
    start_blk(32'h10, 32'h20, 16'd0, 2'd2, 1'b1, 1'b1, 1'b1, 3'd0);
    chk("R8 done", {31'd0, done}, 32'd1);
    chk("R8 busy", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_ignore();     // R9
    logic [31:0] s0, d0;
    run_block("R9 setup", 32'h0000_0800, 32'h0000_0900, 16'd2, 2'd2, 1'b1, 1'b1, 1'b1, 3'd1);
    s0 = src_a; d0 = dst_a;
    beat_pulse();
    beat_pulse();
    chk("R9 src held", src_a, s0);
    chk("R9 dst held", dst_a, d0);
    chk("R9 rem held", {16'd0, rem}, 32'd0);
    chk("R9 done held", {31'd0, done}, 32'd1);
  endtask

  task automatic t_wrap();       // R10
    run_block("R10 wrap", 32'hFFFF_FFF8, 32'hFFFF_FFFF, 16'd3, 2'd2, 1'b1, 1'b1, 1'b0, 3'd0);
  endtask

  task automatic t_latch();      // R11
    start_blk(32'h0000_1000, 32'h0000_2000, 16'd3, 2'd1, 1'b1, 1'b0, 1'b1, 3'd2);
    code = 2'd0; si = 1'b0; di = 1'b1; sel = 1'b0; fld = 3'd6;
    beat_pulse();
    chk("R11 src stride kept", src_a, 32'h0000_1008);
    chk("R11 dst still fixed", dst_a, 32'h0000_2000);
  endtask

  task automatic t_restart();    // R12
    start_blk(32'h0000_A000, 32'h0000_B000, 16'd5, 2'd2, 1'b1, 1'b1, 1'b1, 3'd0);
    beat_pulse();
    beat = 1'b1;
    start_blk(32'h0000_C000, 32'h0000_D000, 16'd2, 2'd0, 1'b1, 1'b1, 1'b1, 3'd0);
    beat = 1'b0;
    chk("R12 src reload", src_a, 32'h0000_C000);
    chk("R12 dst reload", dst_a, 32'h0000_D000);
    chk("R12 rem reload", {16'd0, rem}, 32'd2);
    beat_pulse();
    beat_pulse();
    chk("R12 src end", src_a, 32'h0000_C002);
    chk("R12 done", {31'd0, done}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_src_step();
    t_dst_step();
    t_fixed();
    t_widths();
    t_zero();
    t_ignore();
    t_wrap();
    t_latch();
    t_restart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule